// File: doc/BRIEF.md
# Programmable successor state generator

This block takes one state vector per cycle, with a process number and a choice index, and returns one successor state vector. The state vector is a row of bytes. The top bytes hold the current state number of each process. The block reads the state number of the chosen process. It joins that number with the process number and the choice index to form an address, and reads a wide instruction word from a local memory at that address. Each pipeline stage is steered by its own slice of that word. The first stage picks variables out of the vector and takes immediates from the word. A chain of execute stages, each holding two small ALUs, works on a bank of registers. A final stage routes three registers into each store unit, and the store units patch bytes of the vector.

A new model needs only new instruction words and new model limits, which are loaded through one configuration port while no states are flowing. The pipeline has no stalls. Every accepted input that is allowed reaches the output after a fixed latency, and the inputs around it keep their order. An input is dropped if its process number or choice index is outside the model limits, or if its instruction slot is marked empty.

Top module: `succ_gen`

## Requirements
- R1: After reset, out_valid is low and stays low until an accepted input has had time to cross the pipeline.
- R2: The block accepts an input on every cycle, with no stall. The result for an input presented before clock edge t is on the outputs after edge t+4. Inputs on back-to-back cycles give outputs on back-to-back cycles.
- R3: The instruction address is {in_pid, in_nd, sid}. Here sid is the low 2 bits of byte 6+in_pid of in_vec (byte i is in_vec[8i+7:8i]). The upper bits of that byte do not affect the address.
- R4: Every output byte that no store and no state-number write targets equals the same byte of the input.
- R5: Immediate 0 (instruction bits 13:6) is written as a whole byte into byte 6+in_pid of the output. This write takes priority over any store to that byte.
- R6: Register bank after selection: r0 = byte at instruction bits 2:0, r1 = byte at bits 5:3, r2 = immediate 0, r3 = immediate 1 (bits 21:14), r4..r7 = 0.
- R7: ALU j of execute stage e has its control field at bit 22+9*(2e+j). The field holds op[3:0], src[7:4] and out[8]. The first operand is rj. The second operand is r[src] for src<8; src 8 gives NP, 9 gives PID, 10 gives 1, and 11..15 give 0. The result goes to r(4+2j+out). Op codes: 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 eq, 6 ne, 7 lt, 8 gt, 9 second operand, 10 logical not of the first operand, 11 shift left, 12 shift right, 13 logical not of the second operand, 14 first operand, 15 no write. Registers that no ALU writes pass unchanged to the next stage.
- R8: Store unit k has its field at bit 58+9k. It holds three 3-bit register numbers: condition [2:0], index [5:3] and data [8:6]. The unit writes the data register into byte (index register mod 8) only when the condition register is nonzero.
- R9: When both store units target the same byte, unit 1 wins.
- R10: An instruction with bit 76 set is empty and produces no output.
- R11: An input with in_pid >= NP or in_nd > maximum choice produces no output.
- R12: A configuration write with cfg_addr[4]=1 loads NP from cfg_data[7:0] and the maximum choice from cfg_data[15:8], and leaves the instruction memory unchanged. With cfg_addr[4]=0 it writes cfg_data into instruction slot cfg_addr[3:0] and leaves the limits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Bit 4 selects the limit register; bits 3:0 select the instruction slot |
| cfg_data | input | 77 | Instruction word or limit values |
| in_valid | input | 1 | Input state is present |
| in_vec | input | 64 | Input state vector, 8 bytes |
| in_pid | input | 1 | Process number |
| in_nd | input | 1 | Choice index |
| out_valid | output | 1 | Successor state is present |
| out_vec | output | 64 | Successor state vector |

## Verification
A wrong instruction fetch, a wrong register routing or a wrong ALU result shows in out_vec on the same cycle that out_valid rises, five clock edges after the input. The test inputs give each byte a distinct value, so a byte taken from the wrong place cannot match its expected value. An error in the validity gating, such as a lost empty-slot flag or a wrong limit comparison, shows as out_valid high or low on that same cycle. An extra stage or a missing stage moves every result by one cycle, and the back-to-back test catches that.

// File: rtl/succ_gen.sv
module alu_unit #(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         we
);
  assign we = (op != 4'd15);
  always_comb begin
    case (op)
      4'd0:    y = a + b;
      4'd1:    y = a - b;
      4'd2:    y = a & b;
      4'd3:    y = a | b;
      4'd4:    y = a ^ b;
      4'd5:    y = W'(a == b);
      4'd6:    y = W'(a != b);
      4'd7:    y = W'(a < b);
      4'd8:    y = W'(a > b);
      4'd9:    y = b;
      4'd10:   y = W'(a == '0);
      4'd11:   y = a << b;
      4'd12:   y = a >> b;
      4'd13:   y = W'(b == '0);
      4'd14:   y = a;
      default: y = '0;
    endcase
  end
endmodule

module succ_gen #(
  parameter int S = 8,
  parameter int W = 8,
  parameter int PW = 1,
  parameter int NW = 1,
  parameter int SW = 2,
  parameter int M = 2,
  parameter int N = 2,
  parameter int A = 2,
  parameter int E = 2,
  parameter int K = 2,
  localparam int T = 2 * A,
  localparam int R = M + N + T,
  localparam int VXW = $clog2(S),
  localparam int RW = $clog2(R),
  localparam int SRCW = $clog2(R + 4),
  localparam int CW = 4 + SRCW + 1,
  localparam int AW = PW + NW + SW,
  localparam int VW = S * W,
  localparam int IMO = M * VXW,
  localparam int EXO = IMO + N * W,
  localparam int PMO = EXO + E * A * CW,
  localparam int NOPB = PMO + K * 3 * RW,
  localparam int IW = NOPB + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW:0]   cfg_addr,
  input  logic [IW-1:0] cfg_data,
  input  logic          in_valid,
  input  logic [VW-1:0] in_vec,
  input  logic [PW-1:0] in_pid,
  input  logic [NW-1:0] in_nd,
  output logic          out_valid,
  output logic [VW-1:0] out_vec
);
  localparam int SB = S - (1 << PW);
  localparam int IXW = NOPB - EXO;
  localparam int PMW = K * 3 * RW;

  logic [IW-1:0] imem [1 << AW];
  logic [7:0]    np_q, mx_q;

  always_ff @(posedge clk)
    if (cfg_we && !cfg_addr[AW]) imem[cfg_addr[AW-1:0]] <= cfg_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      np_q <= '0;
      mx_q <= '0;
    end else if (cfg_we && cfg_addr[AW]) begin
      np_q <= cfg_data[7:0];
      mx_q <= cfg_data[15:8];
    end

  wire [SW-1:0] sid  = in_vec[(SB + int'(in_pid)) * W +: SW];
  wire [AW-1:0] fadr = {in_pid, in_nd, sid};
  wire          in_ok = (8'(in_pid) < np_q) && (8'(in_nd) <= mx_q);

  logic [IW-1:0] f_ins;
  logic [VW-1:0] f_vec;
  logic [PW-1:0] f_pid;
  logic          f_v;

  always_ff @(posedge clk) begin
    f_ins <= imem[fadr];
    f_vec <= in_vec;
    f_pid <= in_pid;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) f_v <= 1'b0;
    else        f_v <= in_valid && in_ok;

  logic [R*W-1:0] sel;
  always_comb begin
    sel = '0;
    for (int i = 0; i < M; i++)
      sel[i*W +: W] = f_vec[int'(f_ins[i*VXW +: VXW]) * W +: W];
    for (int j = 0; j < N; j++)
      sel[(M+j)*W +: W] = f_ins[IMO + j*W +: W];
  end

  logic [R*W-1:0] rq  [E+1];
  logic [VW-1:0]  vq  [E+1];
  logic [PW-1:0]  pq  [E+1];
  logic           vld [E+1];
  logic [IXW-1:0] iq  [E];
  logic [PMW-1:0] pm;

  always_ff @(posedge clk) begin
    rq[0] <= sel;
    vq[0] <= f_vec;
    pq[0] <= f_pid;
    iq[0] <= f_ins[NOPB-1:EXO];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) vld[0] <= 1'b0;
    else        vld[0] <= f_v && !f_ins[NOPB];

  for (genvar e = 0; e < E; e++) begin : g_ex
    logic [W-1:0]   ya [A];
    logic           wa [A];
    logic [R*W-1:0] nx;

    for (genvar a = 0; a < A; a++) begin : g_alu
      wire [SRCW-1:0] src = iq[e][a*CW + 4 +: SRCW];
      logic [W-1:0]   opb;
      always_comb begin
        if (int'(src) < R) opb = rq[e][int'(src) * W +: W];
        else begin
          case (int'(src) - R)
            0:       opb = W'(np_q);
            1:       opb = W'(pq[e]);
            2:       opb = W'(1);
            default: opb = '0;
          endcase
        end
      end
      alu_unit #(.W(W)) u_alu (
        .op(iq[e][a*CW +: 4]),
        .a(rq[e][a*W +: W]),
        .b(opb),
        .y(ya[a]),
        .we(wa[a])
      );
    end

    always_comb begin
      nx = rq[e];
      for (int a = 0; a < A; a++)
        if (wa[a]) nx[(M + N + 2*a + int'(iq[e][a*CW + CW - 1])) * W +: W] = ya[a];
    end

    always_ff @(posedge clk) begin
      rq[e+1] <= nx;
      vq[e+1] <= vq[e];
      pq[e+1] <= pq[e];
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) vld[e+1] <= 1'b0;
      else        vld[e+1] <= vld[e];

    if (e < E - 1) begin : g_pass
      always_ff @(posedge clk) iq[e+1] <= iq[e] >> (A * CW);
    end else begin : g_last
      always_ff @(posedge clk) pm <= iq[e][A*CW +: PMW];
    end
  end

  logic [VW-1:0]  ov;
  logic [W-1:0]   cnd, dat;
  logic [VXW-1:0] ixb;

  always_comb begin
    ov  = vq[E];
    cnd = '0;
    dat = '0;
    ixb = '0;
    for (int k = 0; k < K; k++) begin
      cnd = rq[E][int'(pm[k*3*RW +: RW]) * W +: W];
      ixb = rq[E][int'(pm[k*3*RW + RW +: RW]) * W +: VXW];
      dat = rq[E][int'(pm[k*3*RW + 2*RW +: RW]) * W +: W];
      if (cnd != '0) ov[int'(ixb) * W +: W] = dat;
    end
    ov[(SB + int'(pq[E])) * W +: W] = rq[E][M*W +: W];
  end

  always_ff @(posedge clk) out_vec <= ov;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= vld[E];
endmodule

module succ_gen_chk #(
  parameter int AW = 4,
  parameter int PW = 1,
  parameter int NW = 1,
  parameter int LAT = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [AW:0]   cfg_addr,
  input logic [15:0]   cfg_lo,
  input logic          in_valid,
  input logic [PW-1:0] in_pid,
  input logic [NW-1:0] in_nd,
  input logic          out_valid,
  input logic [7:0]    np_q
);
  logic [LAT-1:0] vh, bh;
  logic [7:0]     npt, mxt, cnt;
  wire bad = in_valid && ((8'(in_pid) >= npt) || (8'(in_nd) > mxt));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vh <= '0; bh <= '0; npt <= '0; mxt <= '0; cnt <= '0;
    end else begin
      vh <= {vh[LAT-2:0], in_valid};
      bh <= {bh[LAT-2:0], bad};
      if (int'(cnt) < LAT) cnt <= cnt + 8'd1;
      if (cfg_we && cfg_addr[AW]) begin
        npt <= cfg_lo[7:0];
        mxt <= cfg_lo[15:8];
      end
    end

  assert_no_early_output_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt) < LAT) |-> !out_valid);

  assert_fixed_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> vh[LAT-1]);

  assert_limit_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !bh[LAT-1]);

  assert_cfg_split_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_addr[AW]) |=> $stable(np_q));
endmodule

bind succ_gen succ_gen_chk #(.AW(AW), .PW(PW), .NW(NW), .LAT(E + 3)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .cfg_we(cfg_we),
  .cfg_addr(cfg_addr),
  .cfg_lo(cfg_data[15:0]),
  .in_valid(in_valid),
  .in_pid(in_pid),
  .in_nd(in_nd),
  .out_valid(out_valid),
  .np_q(np_q)
);

// File: tb/succ_gen_test.sv
module succ_gen_test;
  logic        clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, in_valid = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [76:0] cfg_data = '0;
  logic [63:0] in_vec = '0;
  logic        in_pid = 1'b0, in_nd = 1'b0;
  logic        out_valid;
  logic [63:0] out_vec;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  succ_gen uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .in_valid(in_valid), .in_vec(in_vec), .in_pid(in_pid), .in_nd(in_nd),
    .out_valid(out_valid), .out_vec(out_vec)
  );

  localparam logic [63:0] V0 = 64'h02_00_66_55_44_33_22_11;

  function automatic logic [8:0] alu(input logic [3:0] op, input logic [3:0] src, input logic o);
    return {o, src, op};
  endfunction
  function automatic logic [8:0] grp(input logic [2:0] c, input logic [2:0] i, input logic [2:0] d);
    return {d, i, c};
  endfunction
  function automatic logic [76:0] ins(input logic [2:0] s0, input logic [2:0] s1,
                                      input logic [7:0] i0, input logic [7:0] i1,
                                      input logic [8:0] a00, input logic [8:0] a01,
                                      input logic [8:0] a10, input logic [8:0] a11,
                                      input logic [8:0] g0, input logic [8:0] g1);
    return {1'b0, g1, g0, a11, a10, a01, a00, i1, i0, s1, s0};
  endfunction

  logic [8:0] OFF, GOFF;
  initial begin
    OFF  = alu(4'd15, 4'd0, 1'b0);
    GOFF = grp(3'd3, 3'd3, 3'd3);
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic cfg(input logic [4:0] a, input logic [76:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic limits(input logic [7:0] np, input logic [7:0] mx);
    cfg(5'h10, {{61{1'b1}}, mx, np});
  endtask

  task automatic send(input logic p, input logic n, input logic [63:0] v,
                      output logic ov, output logic [63:0] o);
    @(negedge clk);
    in_valid = 1'b1; in_pid = p; in_nd = n; in_vec = v;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    ov = out_valid;
    o  = out_vec;
  endtask

  task automatic t_reset;
    check("R1 out_valid after reset", 64'(out_valid), 64'd0);
  endtask

  task automatic t_sid;
    logic ov; logic [63:0] o;
    cfg(5'd0, ins(0, 0, 8'd1, 8'd0, OFF, OFF, OFF, OFF, GOFF, GOFF));
    send(0, 0, V0, ov, o);
    check("R5 next state valid", 64'(ov), 64'd1);
    check("R4 R5 untouched bytes and state byte", o, 64'h02_01_66_55_44_33_22_11);
  endtask

  task automatic t_addr;
    logic ov; logic [63:0] o;
    cfg(5'd14, ins(0, 0, 8'd3, 8'd0, OFF, OFF, OFF, OFF, GOFF, GOFF));
    cfg(5'd10, ins(0, 0, 8'd1, 8'd0, OFF, OFF, OFF, OFF, GOFF, GOFF));
    send(1, 1, 64'hF2_00_66_55_44_33_22_11, ov, o);
    check("R3 slot 14 chosen", o, 64'h03_00_66_55_44_33_22_11);
    send(1, 0, 64'hF2_00_66_55_44_33_22_11, ov, o);
    check("R3 slot 10 chosen", o, 64'h01_00_66_55_44_33_22_11);
  endtask

  task automatic t_alu;
    logic ov; logic [63:0] o;
    cfg(5'd1, ins(2, 4, 8'd2, 8'd5, alu(0, 1, 0), alu(0, 8, 0), alu(1, 4, 1), OFF,
                  grp(2, 3, 5), grp(2, 6, 4)));
    send(0, 0, 64'h02_01_66_55_44_33_22_11, ov, o);
    check("R6 R7 R8 select, two stages, stores", o, 64'h88_02_AB_55_44_33_22_11);
    cfg(5'd13, ins(0, 1, 8'd0, 8'd2, alu(9, 9, 0), alu(12, 10, 0), alu(0, 4, 1), OFF,
                   grp(4, 3, 5), grp(4, 4, 6)));
    send(1, 1, 64'h01_00_66_55_44_33_22_11, ov, o);
    check("R7 PID and one constants, shift", o, 64'h00_00_66_55_44_12_11_11);
  endtask

  task automatic t_cond;
    logic ov; logic [63:0] o;
    cfg(5'd2, ins(0, 1, 8'd3, 8'd3, alu(5, 8, 0), OFF, OFF, OFF, grp(4, 3, 0), grp(5, 3, 1)));
    send(0, 0, 64'h02_02_66_55_44_33_22_11, ov, o);
    check("R8 zero condition stores nothing", o, 64'h02_03_66_55_44_33_22_11);
  endtask

  task automatic t_collide;
    logic ov; logic [63:0] o;
    cfg(5'd3, ins(0, 1, 8'd0, 8'd4, OFF, OFF, OFF, OFF, grp(0, 3, 0), grp(0, 3, 1)));
    send(0, 0, 64'h02_03_66_55_44_33_22_11, ov, o);
    check("R9 store unit 1 wins", o, 64'h02_00_66_22_44_33_22_11);
  endtask

  task automatic t_sidwin;
    logic ov; logic [63:0] o;
    cfg(5'd8, ins(0, 0, 8'd2, 8'd7, OFF, OFF, OFF, OFF, grp(0, 3, 0), GOFF));
    send(1, 0, 64'h00_00_66_55_44_33_22_11, ov, o);
    check("R5 state write beats store", o, 64'h02_00_66_55_44_33_22_11);
  endtask

  task automatic t_nop;
    logic ov; logic [63:0] o;
    send(0, 1, 64'h02_00_66_55_44_33_22_11, ov, o);
    check("R10 empty slot gives no output", 64'(ov), 64'd0);
  endtask

  task automatic t_gate;
    logic ov; logic [63:0] o;
    cfg(5'd4, ins(0, 0, 8'd1, 8'd0, OFF, OFF, OFF, OFF, GOFF, GOFF));
    send(0, 1, V0, ov, o);
    check("R11 choice 1 allowed", 64'(ov), 64'd1);
    check("R11 choice 1 result", o, 64'h02_01_66_55_44_33_22_11);
    limits(8'd2, 8'd0);
    send(0, 1, V0, ov, o);
    check("R11 choice above limit dropped", 64'(ov), 64'd0);
    limits(8'd1, 8'd1);
    send(1, 0, 64'h00_00_66_55_44_33_22_11, ov, o);
    check("R11 process at NP dropped", 64'(ov), 64'd0);
    limits(8'd2, 8'd1);
    send(1, 0, 64'h00_00_66_55_44_33_22_11, ov, o);
    check("R11 process allowed again", 64'(ov), 64'd1);
  endtask

  task automatic t_cfg;
    logic ov; logic [63:0] o;
    send(0, 0, V0, ov, o);
    check("R12 limit writes leave slot 0 intact valid", 64'(ov), 64'd1);
    check("R12 limit writes leave slot 0 intact data", o, 64'h02_01_66_55_44_33_22_11);
  endtask

  task automatic t_stream;
    @(negedge clk);
    in_valid = 1'b1; in_pid = 0; in_nd = 0; in_vec = V0;
    @(negedge clk);
    in_vec = 64'h02_01_66_55_44_33_22_11;
    @(negedge clk);
    in_pid = 1; in_nd = 1; in_vec = 64'hF2_00_66_55_44_33_22_11;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check("R2 not before edge t+4", 64'(out_valid), 64'd0);
    @(negedge clk);
    check("R2 first valid", 64'(out_valid), 64'd1);
    check("R2 first data", out_vec, 64'h02_01_66_55_44_33_22_11);
    @(negedge clk);
    check("R2 second valid", 64'(out_valid), 64'd1);
    check("R2 second data", out_vec, 64'h88_02_AB_55_44_33_22_11);
    @(negedge clk);
    check("R2 third valid", 64'(out_valid), 64'd1);
    check("R2 third data", out_vec, 64'h03_00_66_55_44_33_22_11);
    @(negedge clk);
    check("R2 stream ends", 64'(out_valid), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    for (int i = 0; i < 16; i++) cfg(5'(i), {1'b1, 76'd0});
    limits(8'd2, 8'd1);
    t_sid();
    t_addr();
    t_alu();
    t_cond();
    t_collide();
    t_sidwin();
    t_nop();
    t_gate();
    t_cfg();
    t_stream();
    report();
    $finish;
  end
endmodule